// File: doc/BRIEF.md
# Watermark Receive Window Buffer

This block holds words returned by a serial flash read engine until a host takes them. It has 32 slots of 32 bits. The host does not pop one word per read. It reads the stored data through a sliding window of indexed slots. Slot 0 is always the oldest valid word, and each higher index returns the next newer word. When the host has consumed a batch, it releases the batch with a single pop. That pop removes as many words as the programmed watermark.

The watermark is a 5-bit field. The threshold is the field value plus one, so it runs from 1 to 32. The threshold decides when the data-ready flag rises. It also decides how many words one pop removes. There are two read views of the same window. One view returns 32 bits per index. The other returns two neighbouring window slots per 64-bit read.

Pops come from one of two sources:
- **Software mode:** the host issues a pop command.
- **DMA mode:** the block raises a request while the flag is high. It hands out window words in order on each acknowledge. After a full batch of acknowledges it performs the pop itself.

Top module: `rx_window_buf`

## Requirements
- R1: After reset, the fill count is 0. The ready, overflow and DMA request outputs are low, and every window read returns 0.
- R2: A push while fewer than 32 words are held stores the word as the newest entry and raises the fill count by one. The buffer holds up to 32 words.
- R3: ready_o is high exactly when the fill count is at least wmark_i+1. wmark_i is 5 bits, so the threshold runs from 1 to 32.
- R4: rd32_data_o returns the word at position rd32_idx_i counted from the oldest entry, where index 0 is the oldest. An index at or beyond the fill count returns 0.
- R5: rd64_data_o returns window slot 2*rd64_idx_i in bits 31:0 and slot 2*rd64_idx_i+1 in bits 63:32. Both slots follow the same rules as R4.
- R6: In software mode (dma_mode_i=0), a cycle with pop_cmd_i=1 removes the min(wmark_i+1, fill) oldest words at that clock edge. Without pop_cmd_i, no word is removed.
- R7: A pop while fewer words are held than the threshold empties the buffer. The fill count stops at 0.
- R8: A push while 32 words are held is dropped and leaves the stored words unchanged. It sets overflow_o, which stays high until reset.
- R9: A push and a pop in the same cycle both take effect. Whether the push is accepted depends on the fill count at the start of that cycle, before the pop.
- R10: In DMA mode, dma_req_o equals ready_o and pop_cmd_i has no effect. dma_data_o returns window slot k, where k is the number of acknowledges already taken in the current batch.
- R11: In DMA mode, the acknowledge that completes wmark_i+1 handshakes pops that many words at the same edge. It also clears the batch count. From the next cycle, dma_req_o reflects the new fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe from the read engine |
| push_data_i | input | 32 | Word to store |
| wmark_i | input | 5 | Watermark field; threshold = value + 1 |
| dma_mode_i | input | 1 | 1 selects DMA-driven pops, 0 selects software pops |
| pop_cmd_i | input | 1 | Software pop command, one cycle per pop |
| rd32_idx_i | input | 5 | Window index for the 32-bit view |
| rd32_data_o | output | 32 | 32-bit view data |
| rd64_idx_i | input | 4 | Slot-pair index for the 64-bit view |
| rd64_data_o | output | 64 | 64-bit view data |
| ready_o | output | 1 | Data-ready flag |
| fill_o | output | 6 | Number of valid words |
| overflow_o | output | 1 | Sticky flag for a dropped push |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge, one word per cycle |
| dma_data_o | output | 32 | Word offered to the DMA |

## Verification
The hardest state to reach is a full buffer that receives a push and a pop in the same cycle. This case shows whether the full check uses the fill count from before the pop or after it. The stimulus reaches it by filling all 32 slots with a distinct pattern and then pushing once more into the full buffer. It then issues a pop and a push together. After that cycle, the fill count and the new oldest word tell the two orderings apart. The DMA batch counter is checked by holding the pop command high with no acknowledge. The bench then walks a batch word by word, checking dma_data_o before each acknowledge.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic {POP_SW = 1'b0, POP_DMA = 1'b1} pop_src_e;

  function automatic int unsigned pop_amount(int unsigned fill, int unsigned thr);
    return (fill < thr) ? fill : thr;
  endfunction
endpackage

// File: rtl/rxw_store.sv
// Circular storage; DEPTH must be a power of two.
module rxw_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [CW-1:0] pop_n_i,
  output logic [DW-1:0] mem_o [DEPTH],
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] fill_o,
  output logic          overflow_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] fill_q;
  logic          overflow_q;
  logic          accept;

  // full check uses the fill count before any same-cycle pop
  assign accept = push_i && (fill_q != CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q   <= '0;
      wr_ptr_q   <= '0;
      fill_q     <= '0;
      overflow_q <= 1'b0;
    end else begin
      rd_ptr_q <= rd_ptr_q + pop_n_i[AW-1:0];
      wr_ptr_q <= wr_ptr_q + AW'(accept);
      fill_q   <= fill_q - pop_n_i + CW'(accept);
      if (push_i && !accept) overflow_q <= 1'b1;
    end
  end

  assign mem_o      = mem_q;
  assign rd_ptr_o   = rd_ptr_q;
  assign fill_o     = fill_q;
  assign overflow_o = overflow_q;

  a_r2_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CW'(DEPTH));
  a_r7_pop_within_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_n_i <= fill_q);
  a_r8_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_q |=> overflow_q);
  a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == CW'(DEPTH) && push_i && pop_n_i == '0) |=>
      (fill_q == CW'(DEPTH) && $stable(wr_ptr_q) && overflow_q));
endmodule

// File: rtl/rxw_window.sv
module rxw_window #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic [DW-1:0] mem_i [DEPTH],
  input  logic [AW-1:0] rd_ptr_i,
  input  logic [CW-1:0] fill_i,
  input  logic [AW-1:0] idx_i,
  output logic [DW-1:0] data_o
);
  logic [AW-1:0] slot;
  logic          hit;

  assign slot   = rd_ptr_i + idx_i;
  assign hit    = {1'b0, idx_i} < fill_i;
  assign data_o = hit ? mem_i[slot] : '0;
endmodule

// File: rtl/rxw_pop_ctrl.sv
module rxw_pop_ctrl
  import rxw_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_mode_i,
  input  logic          pop_cmd_i,
  input  logic          dma_ack_i,
  input  logic [AW-1:0] wmark_i,
  input  logic [CW-1:0] fill_i,
  output logic          ready_o,
  output logic          dma_req_o,
  output logic [AW-1:0] dma_idx_o,
  output logic [CW-1:0] pop_n_o
);
  pop_src_e      src;
  logic [CW-1:0] thr, cnt_q;
  logic          take, last, do_pop;

  assign src       = pop_src_e'(dma_mode_i);
  assign thr       = {1'b0, wmark_i} + CW'(1);
  assign ready_o   = fill_i >= thr;
  assign dma_req_o = (src == POP_DMA) && ready_o;
  assign take      = dma_req_o && dma_ack_i;
  // >= guards a watermark lowered mid-batch
  assign last      = take && (cnt_q >= thr - CW'(1));
  assign do_pop    = (src == POP_DMA) ? last : pop_cmd_i;
  assign pop_n_o   = do_pop ? CW'(pop_amount(int'(fill_i), int'(thr))) : '0;
  assign dma_idx_o = cnt_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (src == POP_SW)   cnt_q <= '0;
    else if (take)            cnt_q <= last ? '0 : cnt_q + CW'(1);
  end

  a_r6_no_cmd_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_mode_i && !pop_cmd_i) |-> pop_n_o == '0);
  a_r10_cmd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_mode_i && !dma_ack_i) |-> pop_n_o == '0);
  a_r11_batch_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_mode_i && pop_n_o != '0) |=> cnt_q == '0);
  a_r11_req_needs_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> fill_i != '0);
endmodule

// File: rtl/rx_window_buf.sv
module rx_window_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [DW-1:0]   push_data_i,
  input  logic [AW-1:0]   wmark_i,
  input  logic            dma_mode_i,
  input  logic            pop_cmd_i,
  input  logic [AW-1:0]   rd32_idx_i,
  output logic [DW-1:0]   rd32_data_o,
  input  logic [AW-2:0]   rd64_idx_i,
  output logic [2*DW-1:0] rd64_data_o,
  output logic            ready_o,
  output logic [CW-1:0]   fill_o,
  output logic            overflow_o,
  output logic            dma_req_o,
  input  logic            dma_ack_i,
  output logic [DW-1:0]   dma_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, dma_idx;
  logic [CW-1:0] fill, pop_n;

  rxw_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni, .push_i, .push_data_i,
    .pop_n_i(pop_n), .mem_o(mem), .rd_ptr_o(rd_ptr),
    .fill_o(fill), .overflow_o(overflow_o)
  );

  rxw_pop_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .dma_mode_i, .pop_cmd_i, .dma_ack_i, .wmark_i,
    .fill_i(fill), .ready_o(ready_o), .dma_req_o(dma_req_o),
    .dma_idx_o(dma_idx), .pop_n_o(pop_n)
  );

  rxw_window #(.DEPTH(DEPTH), .DW(DW)) u_win32 (
    .mem_i(mem), .rd_ptr_i(rd_ptr), .fill_i(fill),
    .idx_i(rd32_idx_i), .data_o(rd32_data_o)
  );

  rxw_window #(.DEPTH(DEPTH), .DW(DW)) u_win_dma (
    .mem_i(mem), .rd_ptr_i(rd_ptr), .fill_i(fill),
    .idx_i(dma_idx), .data_o(dma_data_o)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    rxw_window #(.DEPTH(DEPTH), .DW(DW)) u_win64 (
      .mem_i(mem), .rd_ptr_i(rd_ptr), .fill_i(fill),
      .idx_i({rd64_idx_i, l[0]}), .data_o(rd64_data_o[l*DW +: DW])
    );
  end

  assign fill_o = fill;

  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == '0) |-> (!ready_o && !dma_req_o && rd32_data_o == '0));
endmodule

// File: tb/sim_rx_window_buf.sv
`timescale 1ns/1ps
module sim_rx_window_buf;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic [4:0]  wmark_i = '0;
  logic        dma_mode_i = 1'b0;
  logic        pop_cmd_i = 1'b0;
  logic [4:0]  rd32_idx_i = '0;
  logic [31:0] rd32_data_o;
  logic [3:0]  rd64_idx_i = '0;
  logic [63:0] rd64_data_o;
  logic        ready_o, overflow_o, dma_req_o;
  logic [5:0]  fill_o;
  logic        dma_ack_i = 1'b0;
  logic [31:0] dma_data_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  rx_window_buf u0 (
    .clk_i(clk), .rst_ni, .push_i, .push_data_i, .wmark_i, .dma_mode_i,
    .pop_cmd_i, .rd32_idx_i, .rd32_data_o, .rd64_idx_i, .rd64_data_o,
    .ready_o, .fill_o, .overflow_o, .dma_req_o, .dma_ack_i, .dma_data_o
  );

  // {push, data, pop, wmark, exp_fill, exp_ready, exp_head}, software mode
  localparam int VW = 78;
  localparam logic [VW-1:0] VEC [10] = '{
    {1'b1, 32'hA1, 1'b0, 5'd2, 6'd1, 1'b0, 32'hA1},
    {1'b1, 32'hA2, 1'b0, 5'd2, 6'd2, 1'b0, 32'hA1},
    {1'b1, 32'hA3, 1'b0, 5'd2, 6'd3, 1'b1, 32'hA1},
    {1'b1, 32'hA4, 1'b0, 5'd2, 6'd4, 1'b1, 32'hA1},
    {1'b0, 32'h00, 1'b1, 5'd2, 6'd1, 1'b0, 32'hA4},
    {1'b1, 32'hA5, 1'b1, 5'd0, 6'd1, 1'b1, 32'hA5},
    {1'b0, 32'h00, 1'b0, 5'd1, 6'd1, 1'b0, 32'hA5},
    {1'b0, 32'h00, 1'b1, 5'd1, 6'd0, 1'b0, 32'h00},
    {1'b1, 32'hA6, 1'b0, 5'd0, 6'd1, 1'b1, 32'hA6},
    {1'b0, 32'h00, 1'b1, 5'd0, 6'd0, 1'b0, 32'h00}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(logic [31:0] d);
    push_i = 1'b1;
    push_data_i = d;
    tick();
    push_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1 reset state
    #12;
    check("R1 fill", 64'(fill_o), 0);
    check("R1 ready", 64'(ready_o), 0);
    check("R1 overflow", 64'(overflow_o), 0);
    check("R1 dma_req", 64'(dma_req_o), 0);
    check("R1 rd32", 64'(rd32_data_o), 0);
    check("R1 rd64", rd64_data_o, 0);
    rst_ni = 1'b1;
    tick();

    // vector table: R2 R3 R6 R7 R9
    for (int i = 0; i < 10; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      push_i      = v[77];
      push_data_i = v[76:45];
      pop_cmd_i   = v[44];
      wmark_i     = v[43:39];
      tick();
      push_i = 1'b0;
      pop_cmd_i = 1'b0;
      check($sformatf("R6 vec%0d fill", i), 64'(fill_o), 64'(v[38:33]));
      check($sformatf("R3 vec%0d ready", i), 64'(ready_o), 64'(v[32]));
      check($sformatf("R4 vec%0d head", i), 64'(rd32_data_o), 64'(v[31:0]));
    end

    // fill to capacity: R2 R3 R4 R5
    wmark_i = 5'd31;
    for (int i = 0; i < 31; i++) push(32'h100 + 32'(i));
    check("R3 31 words below thr 32", 64'(ready_o), 0);
    push(32'h11F);
    check("R2 full fill", 64'(fill_o), 32);
    check("R3 thr 32 reached", 64'(ready_o), 1);
    rd32_idx_i = 5'd31; #1;
    check("R4 idx31 newest", 64'(rd32_data_o), 64'h11F);
    rd64_idx_i = 4'd15; #1;
    check("R5 pair 15", rd64_data_o, {32'h11F, 32'h11E});
    rd64_idx_i = 4'd0; #1;
    check("R5 pair 0", rd64_data_o, {32'h101, 32'h100});

    // R8 push into full buffer
    push(32'hDEAD);
    check("R8 fill kept", 64'(fill_o), 32);
    check("R8 overflow set", 64'(overflow_o), 1);
    check("R8 newest kept", 64'(rd32_data_o), 64'h11F);

    // R9 push and pop at full: push rejected
    wmark_i = 5'd3;
    pop_cmd_i = 1'b1;
    push(32'h999);
    pop_cmd_i = 1'b0;
    check("R9 fill after pop+push at full", 64'(fill_o), 28);
    rd32_idx_i = 5'd0; #1;
    check("R9 head", 64'(rd32_data_o), 64'h104);
    check("R8 overflow sticky", 64'(overflow_o), 1);
    rd32_idx_i = 5'd27; #1;
    check("R4 idx27", 64'(rd32_data_o), 64'h11F);
    rd32_idx_i = 5'd28; #1;
    check("R4 idx past fill", 64'(rd32_data_o), 0);
    rd64_idx_i = 4'd14; #1;
    check("R5 pair past fill", rd64_data_o, 0);
    rd32_idx_i = 5'd0;
    tick();
    check("R6 no cmd keeps fill", 64'(fill_o), 28);

    // DMA mode: R10 R11
    rst_ni = 1'b0; tick(); rst_ni = 1'b1; tick();
    dma_mode_i = 1'b1;
    wmark_i = 5'd2;
    push(32'hB0); push(32'hB1);
    check("R10 req low below thr", 64'(dma_req_o), 0);
    push(32'hB2);
    check("R10 req at thr", 64'(dma_req_o), 1);
    push(32'hB3); push(32'hB4);
    pop_cmd_i = 1'b1; tick(); pop_cmd_i = 1'b0;
    check("R10 sw pop ignored", 64'(fill_o), 5);
    check("R10 dma word 0", 64'(dma_data_o), 64'hB0);
    dma_ack_i = 1'b1; tick();
    check("R10 dma word 1", 64'(dma_data_o), 64'hB1);
    check("R11 no pop mid batch", 64'(fill_o), 5);
    tick();
    check("R10 dma word 2", 64'(dma_data_o), 64'hB2);
    tick();
    dma_ack_i = 1'b0;
    check("R11 batch pop fill", 64'(fill_o), 2);
    check("R11 req re-evaluated", 64'(dma_req_o), 0);
    check("R11 head after pop", 64'(rd32_data_o), 64'hB3);
    dma_ack_i = 1'b1; tick(); dma_ack_i = 1'b0;
    check("R11 ack without req ignored", 64'(fill_o), 2);
    push(32'hB5);
    check("R11 req again", 64'(dma_req_o), 1);
    check("R11 batch restarts at oldest", 64'(dma_data_o), 64'hB3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule